// File: doc/BRIEF.md
# Indirect Extended-Register Sequencer

This block reaches a 16-bit extended register space that sits behind four directly addressed window registers of a peripheral. A single command (extended read, extended write, or a gain-field update) becomes a fixed series of byte transactions on a register-access port. The series loads the window, starts the operation through the window's control register and polls that register until it reads zero. Only then is read data trusted. The physical serial transport sits behind the port and is not part of this block.

Polling is paced by a parameterised interval timer counted in system clocks. The number of polls is bounded. When the budget runs out the operation ends with a timeout status. An error reported by the port ends the operation at once. The gain update is a read-modify-write: it replaces the two top bits of a fixed extended register with a gain code, writes the value back, and then clears the peripheral's status register. One command runs at a time, and `busy` brackets it from acceptance to the `done` pulse.

Top module: `xwin_sequencer`

## Requirements
- R1: An extended write issues one burst of four port writes in this order: value to window 0x1B, address bits 15:8 to 0x1C, address bits 7:0 to 0x1D, control code to 0x1E. `port_last` is high only on the control write.
- R2: An extended read issues a burst of address high (0x1C), address low (0x1D) and control code 0x01 (0x1E). Completion polling follows, then one single read of 0x1B. The byte read is returned on `rdata`.
- R3: After a start burst, the control register 0x1E is polled at once with a single read. A read of 0x00 means the operation is complete. Each further poll follows after the request has been idle for exactly `POLL_TICKS` clock cycles.
- R4: If `POLL_MAX` polls in a row read nonzero, the operation ends with status 01 (timeout) and issues no further port requests.
- R5: A gain command (`cmd_op[1]`=1) reads extended register `GAIN_ADDR` and replaces bits 7:6 with `cmd_gain` (levels 1 to 4 give codes 0x00, 0x40, 0x80, 0xC0). It then writes the result back with control code 0x02 and finally writes 0x00 to register 0x02. `rdata` holds the value written back.
- R6: `cmd_mode` selects the control code. For writes, 00 selects 0x02, 01 selects write-with-verify 0x03, 10 selects auto-increment 0x08, and 11 selects 0x02. For reads, mode bit 1 selects auto-increment read 0x04, otherwise 0x01.
- R7: An error reported on `port_err` ends the command at once with status 10 (bus error). No further port request is made.
- R8: `busy` rises on the cycle after `cmd_valid` is accepted in idle and falls in the cycle in which `done` pulses for exactly one cycle. `cmd_valid` while busy is ignored.
- R9: A port request holds its address, direction and data stable until it is acknowledged or errored.
- R10: After reset, `busy`, `done`, `port_req`, `status` and `rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken only when idle) |
| cmd_op | input | 2 | 00 extended read, 01 extended write, 1x gain update |
| cmd_addr | input | 16 | Extended register address (read/write) |
| cmd_wdata | input | 8 | Value for an extended write |
| cmd_mode | input | 2 | Control-code variant (R6) |
| cmd_gain | input | 2 | Gain code for the gain update |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 timeout, 10 bus error |
| rdata | output | 8 | Value read, or value written by the last command |
| port_req | output | 1 | Transaction request to the register port |
| port_we | output | 1 | 1 write, 0 read |
| port_addr | output | 5 | Direct register address |
| port_wdata | output | 8 | Write data |
| port_last | output | 1 | Last transaction of a burst |
| port_ack | input | 1 | Transaction completed |
| port_err | input | 1 | Transaction failed |
| port_rdata | input | 8 | Read data, valid with `port_ack` |

## Verification
A wrong step counter or a wrong program decode shows at the port on the very next request, as an unexpected address, data or burst marker. The beat log is compared entry by entry, so the first misplaced transaction is reported. A faulty retry counter or interval timer shows up as a wrong number of polls, or a wrong gap between consecutive control-register reads, on the first command that needs more than one poll. Corruption of the held data or of the gain merge appears at the port as the write-back byte within the same command. Broken busy or done bookkeeping is caught within one cycle by the per-clock busy model.

// File: rtl/xwin_pkg.sv
// Shared types and constants for the indirect extended-register sequencer.
// Assumes the window and status registers sit at fixed 5-bit addresses of the
// peripheral and that every command is a fixed program of micro-steps.
package xwin_pkg;

    // Direct register addresses decoded by the peripheral
    localparam logic [4:0] WIN_VAL    = 5'h1B;
    localparam logic [4:0] WIN_HI     = 5'h1C;
    localparam logic [4:0] WIN_LO     = 5'h1D;
    localparam logic [4:0] WIN_CTL    = 5'h1E;
    localparam logic [4:0] REG_STATUS = 5'h02;

    // Control codes written to the window control register
    localparam logic [7:0] CTL_RD_GO     = 8'h01;
    localparam logic [7:0] CTL_WR_GO     = 8'h02;
    localparam logic [7:0] CTL_WR_VERIFY = 8'h03;
    localparam logic [7:0] CTL_RD_INC    = 8'h04;
    localparam logic [7:0] CTL_WR_INC    = 8'h08;
    localparam logic [7:0] CTL_IDLE      = 8'h00;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_WRITE = 2'b01,
        OP_GAIN  = 2'b10
    } xop_t;

    typedef enum logic [1:0] {
        ST_OK      = 2'b00,
        ST_TIMEOUT = 2'b01,
        ST_BUSERR  = 2'b10
    } xstat_t;

    typedef enum logic [3:0] {
        U_WVAL,   // write value window
        U_WHI,    // write address high window
        U_WLO,    // write address low window
        U_CTLR,   // write read-start control code
        U_CTLW,   // write write-start control code
        U_POLL,   // read control window
        U_RVAL,   // read value window
        U_WSTAT,  // clear peripheral status
        U_END     // program finished
    } micro_t;

    // Program table: micro-step for a given operation and step index
    function automatic micro_t prog_step(xop_t op, logic [3:0] idx);
        micro_t m;
        m = U_END;
        case (op)
            OP_READ: begin
                case (idx)
                    4'd0: m = U_WHI;
                    4'd1: m = U_WLO;
                    4'd2: m = U_CTLR;
                    4'd3: m = U_POLL;
                    4'd4: m = U_RVAL;
                    default: m = U_END;
                endcase
            end
            OP_WRITE: begin
                case (idx)
                    4'd0: m = U_WVAL;
                    4'd1: m = U_WHI;
                    4'd2: m = U_WLO;
                    4'd3: m = U_CTLW;
                    4'd4: m = U_POLL;
                    default: m = U_END;
                endcase
            end
            default: begin
                case (idx)
                    4'd0:  m = U_WHI;
                    4'd1:  m = U_WLO;
                    4'd2:  m = U_CTLR;
                    4'd3:  m = U_POLL;
                    4'd4:  m = U_RVAL;
                    4'd5:  m = U_WVAL;
                    4'd6:  m = U_WHI;
                    4'd7:  m = U_WLO;
                    4'd8:  m = U_CTLW;
                    4'd9:  m = U_POLL;
                    4'd10: m = U_WSTAT;
                    default: m = U_END;
                endcase
            end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/xwin_interval.sv
// Poll interval timer. Loaded with TICKS-1 when a retry is scheduled, counts
// down to zero and then idles there. Assumes TICKS >= 1.
module xwin_interval #(
    parameter int TICKS = 2_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS + 1) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down and rest at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= RELOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/xwin_beat_decode.sv
// Turns the current micro-step into one register-port transaction.
// Purely combinational; assumes the controller holds its inputs until the
// transaction is acknowledged or errored.
module xwin_beat_decode
    import xwin_pkg::*;
(
    input  micro_t      micro,
    input  logic        in_beat,
    input  logic [15:0] xaddr,
    input  logic [7:0]  dreg,
    input  logic [1:0]  mode,
    output logic        port_req,
    output logic        port_we,
    output logic [4:0]  port_addr,
    output logic [7:0]  port_wdata,
    output logic        port_last
);
    logic [7:0] ctl_rd;
    logic [7:0] ctl_wr;

    // Select the start codes from the command mode
    always_comb begin
        ctl_rd = mode[1] ? CTL_RD_INC : CTL_RD_GO;
        case (mode)
            2'b01:   ctl_wr = CTL_WR_VERIFY;
            2'b10:   ctl_wr = CTL_WR_INC;
            default: ctl_wr = CTL_WR_GO;
        endcase
    end

    // Map the micro-step to address, direction, data and burst marker
    always_comb begin
        port_req   = in_beat && (micro != U_END);
        port_we    = 1'b1;
        port_addr  = 5'h00;
        port_wdata = 8'h00;
        port_last  = 1'b1;
        case (micro)
            U_WVAL: begin
                port_addr  = WIN_VAL;
                port_wdata = dreg;
                port_last  = 1'b0;
            end
            U_WHI: begin
                port_addr  = WIN_HI;
                port_wdata = xaddr[15:8];
                port_last  = 1'b0;
            end
            U_WLO: begin
                port_addr  = WIN_LO;
                port_wdata = xaddr[7:0];
                port_last  = 1'b0;
            end
            U_CTLR: begin
                port_addr  = WIN_CTL;
                port_wdata = ctl_rd;
            end
            U_CTLW: begin
                port_addr  = WIN_CTL;
                port_wdata = ctl_wr;
            end
            U_POLL: begin
                port_we   = 1'b0;
                port_addr = WIN_CTL;
            end
            U_RVAL: begin
                port_we   = 1'b0;
                port_addr = WIN_VAL;
            end
            U_WSTAT: begin
                port_addr  = REG_STATUS;
                port_wdata = CTL_IDLE;
            end
            default: port_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/xwin_ctrl.sv
// Command controller: accepts one command when idle, walks its micro-program,
// counts polls, merges the gain field and reports the outcome with a single
// done pulse. Assumes the port answers each request with ack or err.
module xwin_ctrl
    import xwin_pkg::*;
#(
    parameter int          POLL_MAX  = 5,
    parameter logic [15:0] GAIN_ADDR = 16'h0187
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] cmd_addr,
    input  logic [7:0]  cmd_wdata,
    input  logic [1:0]  cmd_mode,
    input  logic [1:0]  cmd_gain,
    input  logic        port_ack,
    input  logic        port_err,
    input  logic [7:0]  port_rdata,
    input  logic        tmr_expired,
    output logic        busy,
    output logic        done,
    output logic [1:0]  status,
    output logic [7:0]  dreg,
    output logic [15:0] xaddr,
    output logic [1:0]  mode,
    output micro_t      micro,
    output logic        in_beat,
    output logic        tmr_load
);
    localparam int TRY_W = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_MAX - 1);

    typedef enum logic [1:0] {S_IDLE, S_BEAT, S_WAIT} state_t;

    state_t           state_q;
    xop_t             op_q;
    logic [3:0]       step_q;
    logic [TRY_W-1:0] tries_q;
    logic [1:0]       gain_q;
    logic             poll_busy;
    logic             poll_spent;

    // Current micro-step from the program table
    always_comb micro = prog_step(op_q, step_q);

    assign in_beat    = (state_q == S_BEAT);
    assign poll_busy  = in_beat && (micro == U_POLL) && port_ack && (port_rdata != CTL_IDLE);
    assign poll_spent = (tries_q == TRY_LAST);
    assign tmr_load   = poll_busy && !poll_spent;

    // Sequencing, poll accounting and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_READ;
            step_q  <= '0;
            tries_q <= '0;
            gain_q  <= '0;
            mode    <= '0;
            xaddr   <= '0;
            dreg    <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            status  <= ST_OK;
        end else begin
            done <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        state_q <= S_BEAT;
                        busy    <= 1'b1;
                        step_q  <= '0;
                        tries_q <= '0;
                        gain_q  <= cmd_gain;
                        dreg    <= cmd_wdata;
                        if (cmd_op[1]) begin
                            op_q  <= OP_GAIN;
                            mode  <= 2'b00;
                            xaddr <= GAIN_ADDR;
                        end else begin
                            op_q  <= xop_t'(cmd_op);
                            mode  <= cmd_mode;
                            xaddr <= cmd_addr;
                        end
                    end
                end
                S_BEAT: begin
                    if (micro == U_END) begin
                        state_q <= S_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        status  <= ST_OK;
                    end else if (port_err) begin
                        state_q <= S_IDLE;
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        status  <= ST_BUSERR;
                    end else if (port_ack) begin
                        case (micro)
                            U_POLL: begin
                                if (port_rdata == CTL_IDLE) begin
                                    step_q  <= step_q + 1'b1;
                                    tries_q <= '0;
                                end else if (poll_spent) begin
                                    state_q <= S_IDLE;
                                    busy    <= 1'b0;
                                    done    <= 1'b1;
                                    status  <= ST_TIMEOUT;
                                end else begin
                                    tries_q <= tries_q + 1'b1;
                                    state_q <= S_WAIT;
                                end
                            end
                            U_RVAL: begin
                                dreg   <= (op_q == OP_GAIN) ? {gain_q, port_rdata[5:0]} : port_rdata;
                                step_q <= step_q + 1'b1;
                            end
                            default: step_q <= step_q + 1'b1;
                        endcase
                    end
                end
                S_WAIT: begin
                    if (tmr_expired) state_q <= S_BEAT;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/xwin_sequencer.sv
// Top level of the indirect extended-register sequencer. Connects the
// controller, the transaction decoder and the poll interval timer.
// Assumes POLL_TICKS >= 1 and POLL_MAX >= 1.
module xwin_sequencer #(
    parameter int          POLL_TICKS = 2_000_000,
    parameter int          POLL_MAX   = 5,
    parameter logic [15:0] GAIN_ADDR  = 16'h0187
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] cmd_addr,
    input  logic [7:0]  cmd_wdata,
    input  logic [1:0]  cmd_mode,
    input  logic [1:0]  cmd_gain,
    output logic        busy,
    output logic        done,
    output logic [1:0]  status,
    output logic [7:0]  rdata,
    output logic        port_req,
    output logic        port_we,
    output logic [4:0]  port_addr,
    output logic [7:0]  port_wdata,
    output logic        port_last,
    input  logic        port_ack,
    input  logic        port_err,
    input  logic [7:0]  port_rdata
);
    import xwin_pkg::*;

    micro_t      micro;
    logic        in_beat;
    logic        tmr_load;
    logic        tmr_expired;
    logic [15:0] xaddr;
    logic [1:0]  mode;
    logic [7:0]  dreg;

    xwin_ctrl #(
        .POLL_MAX  (POLL_MAX),
        .GAIN_ADDR (GAIN_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_addr    (cmd_addr),
        .cmd_wdata   (cmd_wdata),
        .cmd_mode    (cmd_mode),
        .cmd_gain    (cmd_gain),
        .port_ack    (port_ack),
        .port_err    (port_err),
        .port_rdata  (port_rdata),
        .tmr_expired (tmr_expired),
        .busy        (busy),
        .done        (done),
        .status      (status),
        .dreg        (dreg),
        .xaddr       (xaddr),
        .mode        (mode),
        .micro       (micro),
        .in_beat     (in_beat),
        .tmr_load    (tmr_load)
    );

    xwin_beat_decode u_dec (
        .micro      (micro),
        .in_beat    (in_beat),
        .xaddr      (xaddr),
        .dreg       (dreg),
        .mode       (mode),
        .port_req   (port_req),
        .port_we    (port_we),
        .port_addr  (port_addr),
        .port_wdata (port_wdata),
        .port_last  (port_last)
    );

    xwin_interval #(
        .TICKS (POLL_TICKS)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    assign rdata = dreg;
endmodule

// File: rtl/xwin_checker.sv
// Protocol checker for the sequencer, bound to every instance of the top.
module xwin_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       port_req,
    input logic       port_we,
    input logic [4:0] port_addr,
    input logic [7:0] port_wdata,
    input logic       port_last,
    input logic       port_ack,
    input logic       port_err
);
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R8
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_req |-> busy);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req && !port_ack && !port_err) |=>
            (port_req && $stable(port_addr) && $stable(port_we) && $stable(port_wdata)));
    // R2
    read_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req && !port_we) |-> (port_addr == 5'h1E || port_addr == 5'h1B));
    // R1
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req && port_we && port_last) |-> (port_addr == 5'h1E || port_addr == 5'h02));
    // R7
    err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_req && port_err) |=> !port_req);
endmodule

bind xwin_sequencer xwin_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .port_req   (port_req),
    .port_we    (port_we),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_last  (port_last),
    .port_ack   (port_ack),
    .port_err   (port_err)
);

// File: tb/test_xwin_sequencer.sv
`timescale 1ns/1ps
module test_xwin_sequencer;
    localparam int TICKS = 20;
    localparam int PMAX  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_addr = 16'h0;
    logic [7:0]  cmd_wdata = 8'h0;
    logic [1:0]  cmd_mode = 2'b00;
    logic [1:0]  cmd_gain = 2'b00;
    logic        busy, done, port_req, port_we, port_last;
    logic [1:0]  status;
    logic [7:0]  rdata, port_wdata;
    logic [4:0]  port_addr;
    logic        port_ack = 1'b0;
    logic        port_err = 1'b0;
    logic [7:0]  port_rdata = 8'h0;

    xwin_sequencer #(.POLL_TICKS(TICKS), .POLL_MAX(PMAX), .GAIN_ADDR(16'h0187)) i_xwin_sequencer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_mode(cmd_mode),
        .cmd_gain(cmd_gain), .busy(busy), .done(done), .status(status),
        .rdata(rdata), .port_req(port_req), .port_we(port_we),
        .port_addr(port_addr), .port_wdata(port_wdata), .port_last(port_last),
        .port_ack(port_ack), .port_err(port_err), .port_rdata(port_rdata)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    // Peripheral model state
    logic [7:0] ext [int];
    logic [7:0] valreg = 8'h0, ahi = 8'h0, alo = 8'h0, ctlv = 8'h0;
    int pend = 0, slave_delay = 0, err_at = -1, beat_idx = 0;
    int stall = 0, wait_n = 0, stat_clears = 0;
    bit held = 0;
    int snap = 0;
    int act_log[$];
    int exp_log[$];
    int poll_times[$];
    bit in_flight = 0;
    int done_count = 0;
    logic [1:0] res_status = 2'b00;
    logic [7:0] res_rdata = 8'h0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int enc(input bit we, input bit last, input logic [4:0] a, input logic [7:0] d);
        return (int'(we) << 14) | (int'(last) << 13) | (int'(a) << 8) | int'(d);
    endfunction

    function automatic logic [7:0] ext_rd(input int a);
        return ext.exists(a) ? ext[a] : 8'h00;
    endfunction

    // Busy model, done capture and register-port responder, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(busy === (in_flight && !done), "R8", "busy vs model", int'(busy), int'(in_flight && !done));
            if (done) begin
                in_flight = 0;
                done_count++;
                res_status = status;
                res_rdata = rdata;
            end
            if (port_ack || port_err) begin
                port_ack = 0;
                port_err = 0;
            end else if (port_req) begin
                if (!held) begin
                    held = 1;
                    wait_n = 0;
                    snap = enc(port_we, port_last, port_addr, port_wdata);
                end else begin
                    chk(snap == enc(port_we, port_last, port_addr, port_wdata), "R9", "held request",
                        enc(port_we, port_last, port_addr, port_wdata), snap);
                end
                if (wait_n < stall) begin
                    wait_n++;
                end else begin
                    held = 0;
                    act_log.push_back(enc(port_we, port_last, port_addr, port_we ? port_wdata : 8'h00));
                    if (err_at == beat_idx) begin
                        port_err = 1;
                        err_at = -1;
                    end else begin
                        port_ack = 1;
                        port_rdata = 8'h00;
                        if (port_we) begin
                            case (port_addr)
                                5'h1B: valreg = port_wdata;
                                5'h1C: ahi = port_wdata;
                                5'h1D: alo = port_wdata;
                                5'h1E: begin
                                    ctlv = port_wdata;
                                    pend = slave_delay;
                                    if (port_wdata == 8'h01 || port_wdata == 8'h04)
                                        valreg = ext_rd({ahi, alo});
                                    else
                                        ext[{ahi, alo}] = valreg;
                                end
                                5'h02: stat_clears++;
                                default: ;
                            endcase
                        end else if (port_addr == 5'h1E) begin
                            poll_times.push_back(cyc);
                            if (pend > 0) begin
                                pend--;
                                port_rdata = ctlv;
                            end
                        end else if (port_addr == 5'h1B) begin
                            port_rdata = valreg;
                        end
                    end
                    beat_idx++;
                end
            end
        end
    end

    // Watchdog: a hung run is one failed check and still ends with the summary
    always @(posedge clk) begin
        if (cyc > 150000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    task automatic exp_wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] ctl, input int polls);
        exp_log.push_back(enc(1, 0, 5'h1B, d));
        exp_log.push_back(enc(1, 0, 5'h1C, a[15:8]));
        exp_log.push_back(enc(1, 0, 5'h1D, a[7:0]));
        exp_log.push_back(enc(1, 1, 5'h1E, ctl));
        for (int i = 0; i < polls; i++) exp_log.push_back(enc(0, 1, 5'h1E, 8'h00));
    endtask

    task automatic exp_rd(input logic [15:0] a, input logic [7:0] ctl, input int polls, input bit with_val);
        exp_log.push_back(enc(1, 0, 5'h1C, a[15:8]));
        exp_log.push_back(enc(1, 0, 5'h1D, a[7:0]));
        exp_log.push_back(enc(1, 1, 5'h1E, ctl));
        for (int i = 0; i < polls; i++) exp_log.push_back(enc(0, 1, 5'h1E, 8'h00));
        if (with_val) exp_log.push_back(enc(0, 1, 5'h1B, 8'h00));
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                          input logic [1:0] md, input logic [1:0] g, input int dly, input bit poke);
        int start;
        act_log.delete();
        poll_times.delete();
        beat_idx = 0;
        slave_delay = dly;
        start = done_count;
        @(posedge clk); #1;
        cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_mode = md; cmd_gain = g;
        @(posedge clk); #1;
        cmd_valid = 0;
        in_flight = 1;
        if (poke) begin
            repeat (3) @(posedge clk);
            #1;
            cmd_valid = 1; cmd_op = 2'b00; cmd_addr = 16'hBEEF;
            @(posedge clk); #1;
            cmd_valid = 0;
        end
        while (done_count == start) @(posedge clk);
        repeat (6) @(posedge clk);
        chk(done_count == start + 1, "R8", "done pulses per command", done_count - start, 1);
    endtask

    task automatic cmp_log(input string req);
        chk(act_log.size() == exp_log.size(), req, "beat count", act_log.size(), exp_log.size());
        for (int i = 0; i < exp_log.size() && i < act_log.size(); i++)
            chk(act_log[i] == exp_log[i], req, $sformatf("beat %0d", i), act_log[i], exp_log[i]);
        exp_log.delete();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R10 reset state
        chk(busy == 0 && done == 0 && port_req == 0, "R10", "idle outputs in reset",
            {busy, done, port_req}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(status == 2'b00 && rdata == 8'h00, "R10", "status/rdata after reset", {status, rdata}, 0);

        // R1 / R3: plain write, two busy polls
        exp_wr(16'h1234, 8'h5A, 8'h02, 3);
        run_op(2'b01, 16'h1234, 8'h5A, 2'b00, 2'b00, 2, 0);
        cmp_log("R1");
        chk(res_status == 2'b00, "R3", "write status", res_status, 0);
        chk(ext_rd(16'h1234) == 8'h5A, "R1", "extended target written", ext_rd(16'h1234), 8'h5A);
        chk(poll_times.size() == 3, "R3", "poll count", poll_times.size(), 3);
        for (int i = 1; i < poll_times.size(); i++)
            chk(poll_times[i] - poll_times[i-1] == TICKS + 1, "R3", "poll spacing",
                poll_times[i] - poll_times[i-1], TICKS + 1);

        // R2: read back with immediate completion
        exp_rd(16'h1234, 8'h01, 1, 1);
        run_op(2'b00, 16'h1234, 8'h00, 2'b00, 2'b00, 0, 0);
        cmp_log("R2");
        chk(res_rdata == 8'h5A, "R2", "read data", res_rdata, 8'h5A);
        chk(res_status == 2'b00, "R2", "read status", res_status, 0);

        // R5: gain update, level 2 on 0xE5 gives 0x65
        ext[16'h0187] = 8'hE5;
        stat_clears = 0;
        exp_rd(16'h0187, 8'h01, 2, 1);
        exp_wr(16'h0187, 8'h65, 8'h02, 2);
        exp_log.push_back(enc(1, 1, 5'h02, 8'h00));
        run_op(2'b10, 16'h0000, 8'h00, 2'b11, 2'b01, 1, 0);
        cmp_log("R5");
        chk(res_rdata == 8'h65, "R5", "merged value", res_rdata, 8'h65);
        chk(ext_rd(16'h0187) == 8'h65, "R5", "gain register", ext_rd(16'h0187), 8'h65);
        chk(stat_clears == 1, "R5", "status cleared once", stat_clears, 1);

        // R5: gain level 4 on 0x12 gives 0xD2
        ext[16'h0187] = 8'h12;
        exp_rd(16'h0187, 8'h01, 1, 1);
        exp_wr(16'h0187, 8'hD2, 8'h02, 1);
        exp_log.push_back(enc(1, 1, 5'h02, 8'h00));
        run_op(2'b11, 16'h0000, 8'h00, 2'b00, 2'b11, 0, 0);
        cmp_log("R5");
        chk(ext_rd(16'h0187) == 8'hD2, "R5", "gain level 4", ext_rd(16'h0187), 8'hD2);

        // R6: control code variants
        exp_wr(16'h2000, 8'h11, 8'h03, 1);
        run_op(2'b01, 16'h2000, 8'h11, 2'b01, 2'b00, 0, 0);
        cmp_log("R6");
        chk(ext_rd(16'h2000) == 8'h11, "R6", "verify write data", ext_rd(16'h2000), 8'h11);
        exp_wr(16'h2001, 8'h22, 8'h08, 1);
        run_op(2'b01, 16'h2001, 8'h22, 2'b10, 2'b00, 0, 0);
        cmp_log("R6");
        exp_wr(16'h2002, 8'h33, 8'h02, 1);
        run_op(2'b01, 16'h2002, 8'h33, 2'b11, 2'b00, 0, 0);
        cmp_log("R6");
        exp_rd(16'h2000, 8'h04, 1, 1);
        run_op(2'b00, 16'h2000, 8'h00, 2'b10, 2'b00, 0, 0);
        cmp_log("R6");
        chk(res_rdata == 8'h11, "R6", "auto-increment read data", res_rdata, 8'h11);
        exp_rd(16'h2001, 8'h01, 1, 1);
        run_op(2'b00, 16'h2001, 8'h00, 2'b01, 2'b00, 0, 0);
        cmp_log("R6");

        // R4: completion never seen
        exp_wr(16'h3000, 8'h44, 8'h02, PMAX);
        run_op(2'b01, 16'h3000, 8'h44, 2'b00, 2'b00, 9, 0);
        cmp_log("R4");
        chk(res_status == 2'b01, "R4", "timeout status", res_status, 1);

        // R7: error in the burst
        err_at = 2;
        exp_log.push_back(enc(1, 0, 5'h1B, 8'h55));
        exp_log.push_back(enc(1, 0, 5'h1C, 8'h40));
        exp_log.push_back(enc(1, 0, 5'h1D, 8'h00));
        run_op(2'b01, 16'h4000, 8'h55, 2'b00, 2'b00, 0, 0);
        cmp_log("R7");
        chk(res_status == 2'b10, "R7", "bus error status", res_status, 2);

        // R7: error on a poll
        err_at = 3;
        exp_rd(16'h1234, 8'h01, 1, 0);
        run_op(2'b00, 16'h1234, 8'h00, 2'b00, 2'b00, 1, 0);
        cmp_log("R7");
        chk(res_status == 2'b10, "R7", "poll error status", res_status, 2);

        // R8: command while busy is ignored
        exp_wr(16'h5000, 8'h66, 8'h02, 2);
        run_op(2'b01, 16'h5000, 8'h66, 2'b00, 2'b00, 1, 1);
        cmp_log("R8");
        chk(res_status == 2'b00, "R8", "status after ignored command", res_status, 0);

        // R9: slow port, requests held
        stall = 3;
        exp_rd(16'h5000, 8'h01, 2, 1);
        run_op(2'b00, 16'h5000, 8'h00, 2'b00, 2'b00, 1, 0);
        cmp_log("R9");
        chk(res_rdata == 8'h66, "R9", "read data with stalls", res_rdata, 8'h66);
        stall = 0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule